// File: doc/BRIEF.md
# BCD Calendar Time Keeper

This block holds the current time of day and calendar date as packed BCD values: a three-digit millisecond field, then seconds, minutes, hours (24-hour), day of month, month and a two-digit year. Every field is counted directly in BCD. The block knows the length of each month, and it gives February a 29th day whenever the year is divisible by four.

The count advances on a tick. A two-bit source select picks what makes that tick. It can be an internal divider that produces a 1 kHz pulse from the system clock. It can be an external 1 kHz reference, or an external 1 Hz reference that advances seconds directly. The fourth setting stops counting. Each external reference is synchronized, and it counts on its rising edge only while its own enable is high.

Software sets any field through a single write port made of a strobe, a field code and a data word. A one-cycle strobe flags each rollover of seconds, minutes, hours, day, month and year. Bus decoding, alarms and interrupt handling belong to the surrounding logic.

Top module: `cal_time_keeper`

## Requirements
- R1: After the asynchronous active-low reset the outputs read ms 0x000, sec 0x00, min 0x00, hour 0x00, day 0x01, month 0x01, year 0x00, and all rollover strobes are low.
- R2: In the 1 kHz modes each tick advances the millisecond field in BCD from 000 to 999. The tick after 999 returns it to 000 and advances seconds by one.
- R3: Seconds and minutes wrap from 59 to 00, and hours wrap from 23 to 00. Each wrap advances the next field up the chain.
- R4: Day wraps to 01 after day 31 in months 01, 03, 05, 07, 08, 10 and 12, and after day 30 in months 04, 06, 09 and 11. Each day wrap advances the month.
- R5: February ends after day 29 when the year value is divisible by 4 (00 included), and after day 28 otherwise.
- R6: Month wraps from 12 to 01 and advances the year. Year wraps from 99 to 00.
- R7: roll_sec, roll_min, roll_hour, roll_day, roll_mon and roll_year each go high for exactly one cycle. That cycle is the first one in which the field shows its wrapped value (00, or 01 for day and month).
- R8: src_sel selects the tick: 0 is the internal divider, one tick every CLK_HZ/1000 clocks; 1 is a rising edge of ref_khz; 2 is a rising edge of ref_hz, which advances seconds and leaves ms unchanged; 3 stops counting. A reference that is not selected has no effect. An external edge shows on the outputs after the third clock edge following the reference going high.
- R9: A rising edge of a selected external reference is ignored while its enable (ref_khz_en or ref_hz_en) is low.
- R10: When wr_en is high, the field named by wr_sel is loaded at the clock edge from wr_data. The codes are 0 ms (12 bits), 1 sec, 2 min, 3 hour, 4 day, 5 month and 6 year (bits 7:0). Writing seconds also clears ms. A tick in the same cycle as a write is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_sel | input | 2 | Tick source: 0 internal, 1 ext 1 kHz, 2 ext 1 Hz, 3 stopped |
| ref_khz | input | 1 | External 1 kHz reference |
| ref_khz_en | input | 1 | Qualifies ref_khz edges |
| ref_hz | input | 1 | External 1 Hz reference |
| ref_hz_en | input | 1 | Qualifies ref_hz edges |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field code for the write |
| wr_data | input | 12 | BCD write value |
| ms_bcd | output | 12 | Milliseconds, 3 BCD digits |
| sec_bcd | output | 8 | Seconds |
| min_bcd | output | 8 | Minutes |
| hour_bcd | output | 8 | Hours, 24-hour |
| day_bcd | output | 8 | Day of month |
| mon_bcd | output | 8 | Month |
| year_bcd | output | 8 | Two-digit year |
| roll_sec | output | 1 | Seconds rollover strobe |
| roll_min | output | 1 | Minutes rollover strobe |
| roll_hour | output | 1 | Hours rollover strobe |
| roll_day | output | 1 | Day rollover strobe |
| roll_mon | output | 1 | Month rollover strobe |
| roll_year | output | 1 | Year rollover strobe |

## Verification
The counting chain is started from preset values just short of each boundary. The presets cover a plain millisecond step, ms 999 carrying into seconds, a full 23:59:59.999 wrap into the next day, and the ends of 30-day and 31-day months. They also cover February in a leap year, in a non-leap year and in year 00, and the last tick of 31 Dec 99. Each preset separates a correct month-length or leap rule from an off-by-one one, and the strobe sampled one cycle later separates a one-cycle pulse from a level. The source patterns are edges of the unselected reference, edges with the enable low, and a write landing on the same edge as a tick. An internal divider run is sampled one clock before and at its expected tick, which separates the right period from a neighbouring one.

// File: rtl/cal_pkg.sv
package cal_pkg;

    typedef enum logic [1:0] {
        SRC_INT = 2'd0,
        SRC_KHZ = 2'd1,
        SRC_HZ  = 2'd2,
        SRC_OFF = 2'd3
    } tick_src_e;

    localparam logic [2:0] FLD_MS   = 3'd0;
    localparam logic [2:0] FLD_SEC  = 3'd1;
    localparam logic [2:0] FLD_MIN  = 3'd2;
    localparam logic [2:0] FLD_HOUR = 3'd3;
    localparam logic [2:0] FLD_DAY  = 3'd4;
    localparam logic [2:0] FLD_MON  = 3'd5;
    localparam logic [2:0] FLD_YEAR = 3'd6;

    // Divisible by 4 in packed BCD: an even tens digit needs units 0/4/8,
    // an odd tens digit needs units 2/6.
    function automatic logic bcd_leap(input logic [7:0] yr);
        logic [3:0] u;
        u = yr[3:0];
        if (yr[4] == 1'b0)
            return (u == 4'd0) || (u == 4'd4) || (u == 4'd8);
        else
            return (u == 4'd2) || (u == 4'd6);
    endfunction

    function automatic logic [7:0] bcd_month_end(input logic [7:0] mon, input logic leap);
        case (mon)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/cal_tick_src.sv
module cal_tick_src #(
    parameter int DIV = 50000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src_sel,
    input  logic       ref_khz,
    input  logic       ref_khz_en,
    input  logic       ref_hz,
    input  logic       ref_hz_en,
    output logic       tick_khz,
    output logic       tick_hz
);
    import cal_pkg::*;

    localparam int NCH = 2;
    localparam int CW  = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] CNT_TOP = CW'(DIV - 1);

    logic [NCH-1:0] ref_in;
    logic [NCH-1:0] ref_en;
    logic [NCH-1:0] edge_ok;

    assign ref_in = {ref_hz, ref_khz};
    assign ref_en = {ref_hz_en, ref_khz_en};

    typedef struct packed {
        logic [1:0] sync;
        logic       prev;
    } chan_t;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        chan_t ch_d, ch_q;

        always_comb begin
            ch_d      = ch_q;
            ch_d.sync = {ch_q.sync[0], ref_in[g]};
            ch_d.prev = ch_q.sync[1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ch_q <= '0;
            else        ch_q <= ch_d;
        end

        assign edge_ok[g] = ch_q.sync[1] & ~ch_q.prev & ref_en[g];
    end

    logic [CW-1:0] cnt_d, cnt_q;
    logic          div_tick;
    tick_src_e     src;

    assign src      = tick_src_e'(src_sel);
    assign div_tick = (src == SRC_INT) && (cnt_q == CNT_TOP);

    always_comb begin
        cnt_d = cnt_q;
        if (src != SRC_INT)  cnt_d = '0;
        else if (div_tick)   cnt_d = '0;
        else                 cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_khz = div_tick | ((src == SRC_KHZ) & edge_ok[0]);
    assign tick_hz  = (src == SRC_HZ) & edge_ok[1];

    // R8: every tick is a single-cycle pulse
    p_tick_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_khz | tick_hz) |=> !(tick_khz | tick_hz));

    // R9: a disabled 1 Hz reference never yields a tick
    p_hz_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_hz_en |-> !tick_hz);

endmodule

// File: rtl/cal_bcd_field.sv
module cal_bcd_field #(
    parameter int                  DIGITS = 2,
    parameter logic [4*DIGITS-1:0] BASE   = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  adv,
    input  logic                  ld,
    input  logic [4*DIGITS-1:0]   ld_val,
    input  logic [4*DIGITS-1:0]   last,
    output logic [4*DIGITS-1:0]   val,
    output logic                  carry,
    output logic                  roll
);
    localparam int W = 4 * DIGITS;

    typedef struct packed {
        logic [W-1:0] val;
        logic         roll;
    } fld_t;

    fld_t         st_d, st_q;
    logic [W-1:0] inc_v;

    // BCD increment, digit by digit with a ripple carry
    always_comb begin
        logic c;
        inc_v = st_q.val;
        c     = 1'b1;
        for (int i = 0; i < DIGITS; i++) begin
            if (c) begin
                if (inc_v[4*i +: 4] >= 4'd9) begin
                    inc_v[4*i +: 4] = 4'd0;
                end else begin
                    inc_v[4*i +: 4] = inc_v[4*i +: 4] + 4'd1;
                    c = 1'b0;
                end
            end
        end
    end

    assign carry = adv && !ld && (st_q.val >= last);

    always_comb begin
        st_d      = st_q;
        st_d.roll = 1'b0;
        if (ld) begin
            st_d.val = ld_val;
        end else if (adv) begin
            st_d.val  = carry ? BASE : inc_v;
            st_d.roll = carry;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{val: BASE, roll: 1'b0};
        else        st_q <= st_d;
    end

    assign val  = st_q.val;
    assign roll = st_q.roll;

    // R7: a rollover strobe coincides with the wrapped value
    p_roll_to_base_r7: assert property (@(posedge clk) disable iff (!rst_n)
        roll |-> (val == BASE));

    // R7: the strobe lasts one cycle unless advanced again
    p_roll_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (roll && !adv) |=> !roll);

    // R10: a load shows its value on the next cycle
    p_ld_value_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (val == $past(ld_val)));

    // R8: with no tick and no load the field holds
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !ld) |=> $stable(val));

endmodule

// File: rtl/cal_time_keeper.sv
module cal_time_keeper #(
    parameter int CLK_HZ  = 50_000_000,
    parameter int TICK_HZ = 1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  src_sel,
    input  logic        ref_khz,
    input  logic        ref_khz_en,
    input  logic        ref_hz,
    input  logic        ref_hz_en,
    input  logic        wr_en,
    input  logic [2:0]  wr_sel,
    input  logic [11:0] wr_data,
    output logic [11:0] ms_bcd,
    output logic [7:0]  sec_bcd,
    output logic [7:0]  min_bcd,
    output logic [7:0]  hour_bcd,
    output logic [7:0]  day_bcd,
    output logic [7:0]  mon_bcd,
    output logic [7:0]  year_bcd,
    output logic        roll_sec,
    output logic        roll_min,
    output logic        roll_hour,
    output logic        roll_day,
    output logic        roll_mon,
    output logic        roll_year
);
    import cal_pkg::*;

    localparam int DIV = CLK_HZ / TICK_HZ;

    logic tick_khz, tick_hz;

    cal_tick_src #(.DIV(DIV)) i_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_sel    (src_sel),
        .ref_khz    (ref_khz),
        .ref_khz_en (ref_khz_en),
        .ref_hz     (ref_hz),
        .ref_hz_en  (ref_hz_en),
        .tick_khz   (tick_khz),
        .tick_hz    (tick_hz)
    );

    // Carry chain and write decode, all combinational
    logic adv_ms, adv_sec, adv_min, adv_hour, adv_day, adv_mon, adv_year;
    logic c_ms, c_sec, c_min, c_hour, c_day, c_mon, c_year;
    logic ld_ms, ld_sec, ld_min, ld_hour, ld_day, ld_mon, ld_year;
    logic [11:0] ms_ld_val;
    logic [7:0]  day_last;
    logic        r_ms;

    always_comb begin
        adv_ms   = tick_khz & ~wr_en;
        adv_sec  = (tick_hz & ~wr_en) | c_ms;
        adv_min  = c_sec;
        adv_hour = c_min;
        adv_day  = c_hour;
        adv_mon  = c_day;
        adv_year = c_mon;

        ld_ms    = wr_en && ((wr_sel == FLD_MS) || (wr_sel == FLD_SEC));
        ld_sec   = wr_en && (wr_sel == FLD_SEC);
        ld_min   = wr_en && (wr_sel == FLD_MIN);
        ld_hour  = wr_en && (wr_sel == FLD_HOUR);
        ld_day   = wr_en && (wr_sel == FLD_DAY);
        ld_mon   = wr_en && (wr_sel == FLD_MON);
        ld_year  = wr_en && (wr_sel == FLD_YEAR);

        ms_ld_val = (wr_sel == FLD_MS) ? wr_data : 12'h000;
        day_last  = bcd_month_end(mon_bcd, bcd_leap(year_bcd));
    end

    cal_bcd_field #(.DIGITS(3), .BASE(12'h000)) i_ms (
        .clk(clk), .rst_n(rst_n), .adv(adv_ms), .ld(ld_ms), .ld_val(ms_ld_val),
        .last(12'h999), .val(ms_bcd), .carry(c_ms), .roll(r_ms));

    cal_bcd_field #(.DIGITS(2), .BASE(8'h00)) i_sec (
        .clk(clk), .rst_n(rst_n), .adv(adv_sec), .ld(ld_sec), .ld_val(wr_data[7:0]),
        .last(8'h59), .val(sec_bcd), .carry(c_sec), .roll(roll_sec));

    cal_bcd_field #(.DIGITS(2), .BASE(8'h00)) i_min (
        .clk(clk), .rst_n(rst_n), .adv(adv_min), .ld(ld_min), .ld_val(wr_data[7:0]),
        .last(8'h59), .val(min_bcd), .carry(c_min), .roll(roll_min));

    cal_bcd_field #(.DIGITS(2), .BASE(8'h00)) i_hour (
        .clk(clk), .rst_n(rst_n), .adv(adv_hour), .ld(ld_hour), .ld_val(wr_data[7:0]),
        .last(8'h23), .val(hour_bcd), .carry(c_hour), .roll(roll_hour));

    cal_bcd_field #(.DIGITS(2), .BASE(8'h01)) i_day (
        .clk(clk), .rst_n(rst_n), .adv(adv_day), .ld(ld_day), .ld_val(wr_data[7:0]),
        .last(day_last), .val(day_bcd), .carry(c_day), .roll(roll_day));

    cal_bcd_field #(.DIGITS(2), .BASE(8'h01)) i_mon (
        .clk(clk), .rst_n(rst_n), .adv(adv_mon), .ld(ld_mon), .ld_val(wr_data[7:0]),
        .last(8'h12), .val(mon_bcd), .carry(c_mon), .roll(roll_mon));

    cal_bcd_field #(.DIGITS(2), .BASE(8'h00)) i_year (
        .clk(clk), .rst_n(rst_n), .adv(adv_year), .ld(ld_year), .ld_val(wr_data[7:0]),
        .last(8'h99), .val(year_bcd), .carry(c_year), .roll(roll_year));

    // R3: hours only wrap after 23
    p_hour_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        roll_hour |-> ($past(hour_bcd) >= 8'h23));

    // R4: the day only wraps from a month-end value
    p_day_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        roll_day |-> ($past(day_bcd) >= 8'h28));

    // R5: leaving February needs the leap-aware last day
    p_feb_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (roll_day && mon_bcd == 8'h03) |->
        ($past(day_bcd) >= (bcd_leap(year_bcd) ? 8'h29 : 8'h28)));

    // R6: the year strobe needs the month strobe with it
    p_year_chain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        roll_year |-> roll_mon);

    // R10: a seconds write leaves ms at zero
    p_sec_wr_clears_ms_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == FLD_SEC) |=> (ms_bcd == 12'h000));

endmodule

// File: tb/test_cal_time_keeper.sv
module test_cal_time_keeper;

    localparam int DIV = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  src_sel = 2'd3;
    logic        ref_khz = 1'b0, ref_khz_en = 1'b1;
    logic        ref_hz = 1'b0, ref_hz_en = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = 3'd0;
    logic [11:0] wr_data = 12'h0;
    logic [11:0] ms_bcd;
    logic [7:0]  sec_bcd, min_bcd, hour_bcd, day_bcd, mon_bcd, year_bcd;
    logic        roll_sec, roll_min, roll_hour, roll_day, roll_mon, roll_year;

    always #10 clk = ~clk;

    cal_time_keeper #(.CLK_HZ(DIV * 1000), .TICK_HZ(1000)) i_cal_time_keeper (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel),
        .ref_khz(ref_khz), .ref_khz_en(ref_khz_en),
        .ref_hz(ref_hz), .ref_hz_en(ref_hz_en),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ms_bcd(ms_bcd), .sec_bcd(sec_bcd), .min_bcd(min_bcd), .hour_bcd(hour_bcd),
        .day_bcd(day_bcd), .mon_bcd(mon_bcd), .year_bcd(year_bcd),
        .roll_sec(roll_sec), .roll_min(roll_min), .roll_hour(roll_hour),
        .roll_day(roll_day), .roll_mon(roll_mon), .roll_year(roll_year));

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // bench model
    int m_ms = 0, m_s = 0, m_mi = 0, m_h = 0, m_d = 1, m_mo = 1, m_y = 0;
    logic [5:0] m_roll = '0;

    typedef struct {
        string       tag;
        logic [11:0] ms;
        logic [7:0]  s, mi, h, d, mo, y;
        logic [5:0]  roll;
    } item_t;

    item_t sb_q[$];

    function automatic logic [7:0] b2(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic logic [11:0] b3(input int v);
        return {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
    endfunction

    function automatic int days_in(input int mo, input int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic step_sec();
        m_roll = '0;
        m_s++;
        if (m_s == 60) begin
            m_s = 0; m_roll[0] = 1'b1; m_mi++;
            if (m_mi == 60) begin
                m_mi = 0; m_roll[1] = 1'b1; m_h++;
                if (m_h == 24) begin
                    m_h = 0; m_roll[2] = 1'b1; m_d++;
                    if (m_d > days_in(m_mo, m_y)) begin
                        m_d = 1; m_roll[3] = 1'b1; m_mo++;
                        if (m_mo == 13) begin
                            m_mo = 1; m_roll[4] = 1'b1; m_y++;
                            if (m_y == 100) begin
                                m_y = 0; m_roll[5] = 1'b1;
                            end
                        end
                    end
                end
            end
        end
    endtask

    task automatic step_ms();
        m_ms++;
        if (m_ms == 1000) begin
            m_ms = 0;
            step_sec();
        end else begin
            m_roll = '0;
        end
    endtask

    // driver helpers
    task automatic expect_now(input string tag);
        item_t it;
        it.tag = tag;
        it.ms = b3(m_ms); it.s = b2(m_s); it.mi = b2(m_mi); it.h = b2(m_h);
        it.d = b2(m_d); it.mo = b2(m_mo); it.y = b2(m_y); it.roll = m_roll;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic write_field(input int code, input int v);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'(code);
        wr_data = (code == 0) ? b3(v) : {4'h0, b2(v)};
        @(negedge clk);
        wr_en = 1'b0;
        m_roll = '0;
        case (code)
            0: m_ms = v;
            1: begin m_s = v; m_ms = 0; end
            2: m_mi = v;
            3: m_h = v;
            4: m_d = v;
            5: m_mo = v;
            default: m_y = v;
        endcase
    endtask

    task automatic set_time(input int h, input int mi, input int s, input int ms);
        write_field(3, h); write_field(2, mi); write_field(1, s); write_field(0, ms);
    endtask

    task automatic set_date(input int d, input int mo, input int y);
        write_field(6, y); write_field(5, mo); write_field(4, d);
    endtask

    // raise a reference; returns just after the edge that applies the tick
    task automatic raise_ref(input bit hz);
        @(negedge clk);
        if (hz) ref_hz = 1'b1; else ref_khz = 1'b1;
        repeat (3) @(posedge clk);
    endtask

    task automatic release_refs();
        @(negedge clk);
        ref_hz = 1'b0; ref_khz = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // monitor
    initial begin
        forever begin
            item_t it;
            wait (sb_q.size() > 0);
            @(negedge clk);
            it = sb_q[0];
            checks++;
            if (ms_bcd !== it.ms || sec_bcd !== it.s || min_bcd !== it.mi ||
                hour_bcd !== it.h || day_bcd !== it.d || mon_bcd !== it.mo ||
                year_bcd !== it.y ||
                {roll_year, roll_mon, roll_day, roll_hour, roll_min, roll_sec} !== it.roll) begin
                errors++;
                $display("FAIL %s: got %h/%h/%h %h:%h:%h.%h roll=%b, expected %h/%h/%h %h:%h:%h.%h roll=%b",
                    it.tag, day_bcd, mon_bcd, year_bcd, hour_bcd, min_bcd, sec_bcd, ms_bcd,
                    {roll_year, roll_mon, roll_day, roll_hour, roll_min, roll_sec},
                    it.d, it.mo, it.y, it.h, it.mi, it.s, it.ms, it.roll);
            end
            void'(sb_q.pop_front());
        end
    end

    // watchdog
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_now("R1 reset values");

        // R2 / R8: 1 kHz reference step
        src_sel = 2'd1;
        raise_ref(1'b0); step_ms(); expect_now("R2 R8 ms step on kHz edge");
        release_refs();

        // R2: 998 -> 999 -> 000 with seconds carry
        src_sel = 2'd3;
        write_field(0, 998);
        src_sel = 2'd1;
        raise_ref(1'b0); step_ms(); expect_now("R2 ms 999");
        release_refs();
        raise_ref(1'b0); step_ms(); expect_now("R2 ms wrap into sec");
        release_refs();

        // R3 / R7: full time-of-day wrap
        src_sel = 2'd3;
        set_time(23, 59, 59, 999);
        src_sel = 2'd1;
        raise_ref(1'b0); step_ms(); expect_now("R3 R7 23:59:59.999 wrap");
        m_roll = '0; expect_now("R7 strobes last one cycle");
        release_refs();

        // R8: 1 Hz mode, ms untouched; kHz edges ignored
        src_sel = 2'd3;
        write_field(1, 10); write_field(0, 123);
        src_sel = 2'd2;
        raise_ref(1'b1); step_sec(); expect_now("R8 hz tick advances sec only");
        release_refs();
        raise_ref(1'b0); m_roll = '0; expect_now("R8 unselected kHz ignored");
        release_refs();

        // R9: enable low blocks the edge
        ref_hz_en = 1'b0;
        raise_ref(1'b1); expect_now("R9 disabled hz edge ignored");
        release_refs();
        ref_hz_en = 1'b1;

        // R4: 30-day and 31-day month ends
        src_sel = 2'd3;
        set_date(30, 4, 21); set_time(23, 59, 59, 0);
        src_sel = 2'd2;
        raise_ref(1'b1); step_sec(); expect_now("R4 Apr 30 -> May 01");
        release_refs();
        src_sel = 2'd3;
        set_date(30, 5, 21); set_time(23, 59, 59, 0);
        src_sel = 2'd2;
        raise_ref(1'b1); step_sec(); expect_now("R4 May 30 -> 31");
        release_refs();

        // R5: February in leap, non-leap and year 00
        src_sel = 2'd3;
        set_date(28, 2, 24); set_time(23, 59, 59, 0);
        src_sel = 2'd2;
        raise_ref(1'b1); step_sec(); expect_now("R5 leap Feb 28 -> 29");
        release_refs();
        src_sel = 2'd3;
        set_time(23, 59, 59, 0);
        src_sel = 2'd2;
        raise_ref(1'b1); step_sec(); expect_now("R5 leap Feb 29 -> Mar 01");
        release_refs();
        src_sel = 2'd3;
        set_date(28, 2, 23); set_time(23, 59, 59, 0);
        src_sel = 2'd2;
        raise_ref(1'b1); step_sec(); expect_now("R5 non-leap Feb 28 -> Mar 01");
        release_refs();
        src_sel = 2'd3;
        set_date(28, 2, 0); set_time(23, 59, 59, 0);
        src_sel = 2'd2;
        raise_ref(1'b1); step_sec(); expect_now("R5 year 00 Feb 28 -> 29");
        release_refs();

        // R6: end of century
        src_sel = 2'd3;
        set_date(31, 12, 99); set_time(23, 59, 59, 0);
        src_sel = 2'd2;
        raise_ref(1'b1); step_sec(); expect_now("R6 R7 31/12/99 -> 01/01/00");
        release_refs();

        // R10: write wins over a tick in the same cycle
        src_sel = 2'd3;
        set_time(5, 10, 20, 0);
        src_sel = 2'd2;
        @(negedge clk); ref_hz = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); wr_en = 1'b1; wr_sel = 3'd2; wr_data = 12'h042;
        @(negedge clk); wr_en = 1'b0;
        m_mi = 42; m_roll = '0;
        expect_now("R10 write drops same-cycle tick");
        release_refs();

        // R10: seconds write clears ms
        src_sel = 2'd3;
        write_field(0, 777);
        write_field(1, 33);
        expect_now("R10 sec write clears ms");

        // R8: internal divider period
        @(negedge clk); src_sel = 2'd0;
        repeat (DIV - 1) @(posedge clk);
        m_roll = '0; expect_now("R8 no divider tick before period");
        @(posedge clk); step_ms(); expect_now("R8 divider tick at period");
        src_sel = 2'd3;

        // R8: stopped mode ignores both references
        raise_ref(1'b1); m_roll = '0; expect_now("R8 stopped mode ignores refs");
        release_refs();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule